// File: doc/BRIEF.md
# Serial Flash Status Register and Command Gate

This block is the command decoder and status-register keeper for the slave side of a serial flash device on an SPI bus. It works in SPI modes 0 and 3. Each transaction opens with a falling chip select, an opcode shifted in MSB first, and optional address or data bytes. The block tracks a write-enable latch, three block-protect bits, a status-write-disable bit and a busy flag. It decides whether each modifying command is accepted, and when chip select rises it either applies the command or drops it.

Accepted program and erase commands go to an external array controller through a one-cycle start strobe with a kind code and an address. The array controller answers with a done pulse. A status write has no array side, so an internal timer of `WRSR_CYCLES` clock cycles stands in for the non-volatile update. The SPI pins are treated as inputs synchronous to `clk_i`, each lasting several clock periods. The block finds SCK edges by comparing SCK with a registered copy of itself.

Top module: `spi_flash_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and `so_oe_o` is 0 whenever `cs_ni` is high.
- R2: After opcode 0x05 the status byte is driven on `so_o` MSB first. A new bit appears on each falling SCK edge, and the byte repeats for as long as chip select stays low. The layout is bit 7 write-disable, bits 6:5 always 0, bits 4:2 protect level (BP2..BP0), bit 1 write-enable latch, bit 0 busy.
- R3: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it. Each must be exactly one byte long.
- R4: Opcode 0x01 with exactly one data byte, while the latch is 1, loads bit 7 and bits 4:2 from that data byte and leaves bits 1:0 untouched by the data. Busy then stays 1 for `WRSR_CYCLES` cycles. When busy clears, the latch clears with it.
- R5: A status write issued while the latch is 0 is ignored.
- R6: While bit 7 is 1 and `wp_ni` is low, a status write is ignored. The latch is left as it was, and bits 7 and 4:2 cannot change.
- R7: Program (0x02, three address bytes and at least one data byte) and sector erase (0xD8, exactly three address bytes) are accepted only when the latch is 1 and the target sector is unprotected. On acceptance, `op_start_o` pulses for one cycle with `op_kind_o` = 1 (program) or 2 (sector erase) and the 24-bit address. Busy stays 1 until `op_done_i`, and then busy and the latch both clear.
- R8: The sector index is address bits 18:16, out of 8 sectors. A nonzero protect level P protects the top min(8, 2^(P-1)) sectors, so levels 4 to 7 protect the whole array. Program or erase aimed at a protected sector is rejected and leaves the status unchanged.
- R9: Bulk erase (0xC7, one byte) is accepted only when the latch is 1 and the protect level is 0. It pulses `op_start_o` with kind 3 and address 0.
- R10: While busy is 1, every opcode other than 0x05 is ignored.
- R11: A command is ignored when chip select rises off a byte boundary or when the byte count does not match the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write-protect pin, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o`; 0 means high impedance |
| op_start_o | output | 1 | One-cycle strobe for an accepted array command |
| op_kind_o | output | 2 | 1 program, 2 sector erase, 3 bulk erase |
| op_addr_o | output | 24 | Address of the accepted array command |
| op_done_i | input | 1 | Completion pulse from the array controller |

## Verification
A command's result appears on the first clock edge at which the registered chip select sees `cs_ni` high. Both `op_start_o` and the status registers change on that edge. The bench waits four clock cycles after raising chip select before it counts start strobes or reads the status back. A status bit on `so_o` is registered on the clock edge that detects a falling SCK, so the bench samples it four cycles after driving SCK low and before the next rising edge. Busy release is checked once `op_done_i` has been pulsed, or once the bench has waited more than `WRSR_CYCLES` cycles after a status write. Busy is also read within a few hundred cycles of acceptance, well inside the timer window.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_WDIS  = 8'h04;
  localparam logic [7:0] OPC_RSTAT = 8'h05;
  localparam logic [7:0] OPC_WSTAT = 8'h01;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SERA  = 8'hD8;
  localparam logic [7:0] OPC_BERA  = 8'hC7;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_PROG = 2'd1,
    OPK_SECT = 2'd2,
    OPK_BULK = 2'd3
  } op_kind_e;
endpackage

// File: rtl/sfsr_rx.sv
module sfsr_rx #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_rise_i,
  input  logic              si_i,
  output logic [7:0]        opcode_o,
  output logic              wr_lock_o,
  output logic [2:0]        wr_lvl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              on_byte_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [6:0] sh_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] byte_in;

  assign byte_in   = {sh_q, si_i};
  assign on_byte_o = (bit_cnt_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_cnt_q  <= '0;
      byte_cnt_o <= '0;
      opcode_o   <= '0;
      wr_lock_o  <= 1'b0;
      wr_lvl_o   <= '0;
      addr_o     <= '0;
    end else if (cs_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_o <= '0;
    end else if (sck_rise_i) begin
      sh_q      <= byte_in[6:0];
      bit_cnt_q <= bit_cnt_q + 3'd1;
      if (bit_cnt_q == 3'd7) begin
        if (byte_cnt_o != '1) byte_cnt_o <= byte_cnt_o + CNT_W'(1);
        if (byte_cnt_o == '0) opcode_o <= byte_in;
        if (byte_cnt_o == CNT_W'(1)) begin
          wr_lock_o <= byte_in[7];
          wr_lvl_o  <= byte_in[4:2];
        end
        if (byte_cnt_o >= CNT_W'(1) && byte_cnt_o <= CNT_W'(ADDR_BYTES))
          addr_o <= {addr_o[ADDR_W-9:0], byte_in};
      end
    end
  end
endmodule

// File: rtl/sfsr_tx.sv
module sfsr_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_fall_i,
  input  logic       rd_en_i,
  input  logic [7:0] status_i,
  output logic       so_o,
  output logic       so_oe_o
);
  logic [2:0] idx_q;
  logic [7:0] snap_q;

  // status is frozen per byte so one byte never mixes two states
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= 3'd7;
      snap_q  <= '0;
      so_o    <= 1'b0;
      so_oe_o <= 1'b0;
    end else if (cs_ni) begin
      idx_q   <= 3'd7;
      so_oe_o <= 1'b0;
    end else if (sck_fall_i && rd_en_i) begin
      so_oe_o <= 1'b1;
      idx_q   <= idx_q - 3'd1;
      if (idx_q == 3'd7) begin
        snap_q <= status_i;
        so_o   <= status_i[7];
      end else begin
        so_o <= snap_q[idx_q];
      end
    end
  end

  assert_oe_needs_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> $past(rd_en_i) && !$past(cs_ni));
endmodule

// File: rtl/sfsr_prot.sv
module sfsr_prot #(
  parameter int SECT_W = 3
) (
  input  logic [2:0]        lvl_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              locked_o
);
  localparam int NSECT = 1 << SECT_W;

  int span;
  always_comb begin
    span = 0;
    if (lvl_i != 3'd0) span = 1 << (int'(lvl_i) - 1);
    if (span > NSECT) span = NSECT;
    locked_o = (span != 0) && (int'(sector_i) >= NSECT - span);
  end
endmodule

// File: rtl/spi_flash_status_ctrl.sv
module spi_flash_status_ctrl
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 3,
  parameter int SECT_LSB    = 16,
  parameter int WRSR_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              wp_ni,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              op_start_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  input  logic              op_done_i
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 3);
  localparam int TMR_W      = $clog2(WRSR_CYCLES + 1);

  logic              sck_q, cs_q;
  logic              sck_rise, sck_fall, cs_rise, exec;
  logic [7:0]        opcode;
  logic              wr_lock;
  logic [2:0]        wr_lvl;
  logic [ADDR_W-1:0] rx_addr;
  logic [CNT_W-1:0]  byte_cnt;
  logic              on_byte, locked, hw_prot, rd_en;
  logic              wel_q, wip_q, lock_q, arr_busy_q;
  logic [2:0]        bp_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [7:0]        status;

  assign sck_rise = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall = ~sck_i & sck_q & ~cs_ni;
  assign cs_rise  = cs_ni & ~cs_q;
  assign exec     = cs_rise & on_byte;
  assign hw_prot  = lock_q & ~wp_ni;
  assign rd_en    = (opcode == OPC_RSTAT) && (byte_cnt != '0);
  assign status   = {lock_q, 2'b00, bp_q, wel_q, wip_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  sfsr_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .cs_ni, .sck_rise_i(sck_rise), .si_i,
    .opcode_o(opcode), .wr_lock_o(wr_lock), .wr_lvl_o(wr_lvl),
    .addr_o(rx_addr), .byte_cnt_o(byte_cnt), .on_byte_o(on_byte)
  );

  sfsr_prot #(.SECT_W(SECT_W)) u_prot (
    .lvl_i(bp_q), .sector_i(rx_addr[SECT_LSB +: SECT_W]), .locked_o(locked)
  );

  sfsr_tx u_tx (
    .clk_i, .rst_ni, .cs_ni, .sck_fall_i(sck_fall), .rd_en_i(rd_en),
    .status_i(status), .so_o, .so_oe_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      lock_q     <= 1'b0;
      bp_q       <= '0;
      arr_busy_q <= 1'b0;
      tmr_q      <= '0;
      op_start_o <= 1'b0;
      op_kind_o  <= OPK_NONE;
      op_addr_o  <= '0;
    end else begin
      op_start_o <= 1'b0;
      if (wip_q) begin
        if (arr_busy_q ? op_done_i : (tmr_q == TMR_W'(1))) begin
          wip_q      <= 1'b0;
          wel_q      <= 1'b0;
          arr_busy_q <= 1'b0;
        end else if (!arr_busy_q) begin
          tmr_q <= tmr_q - TMR_W'(1);
        end
      end else if (exec) begin
        unique case (opcode)
          OPC_WEN:  if (byte_cnt == CNT_W'(1)) wel_q <= 1'b1;
          OPC_WDIS: if (byte_cnt == CNT_W'(1)) wel_q <= 1'b0;
          OPC_WSTAT:
            if (byte_cnt == CNT_W'(2) && wel_q && !hw_prot) begin
              lock_q <= wr_lock;
              bp_q   <= wr_lvl;
              wip_q  <= 1'b1;
              tmr_q  <= TMR_W'(WRSR_CYCLES);
            end
          OPC_PROG, OPC_SERA:
            if (wel_q && !locked &&
                ((opcode == OPC_SERA) ? (byte_cnt == CNT_W'(ADDR_BYTES + 1))
                                      : (byte_cnt >= CNT_W'(ADDR_BYTES + 2)))) begin
              wip_q      <= 1'b1;
              arr_busy_q <= 1'b1;
              op_start_o <= 1'b1;
              op_kind_o  <= (opcode == OPC_SERA) ? OPK_SECT : OPK_PROG;
              op_addr_o  <= rx_addr;
            end
          OPC_BERA:
            if (byte_cnt == CNT_W'(1) && wel_q && bp_q == 3'd0) begin
              wip_q      <= 1'b1;
              arr_busy_q <= 1'b1;
              op_start_o <= 1'b1;
              op_kind_o  <= OPK_BULK;
              op_addr_o  <= '0;
            end
          default: ;
        endcase
      end
    end
  end

  assert_hw_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wp_ni) |=> ($stable(bp_q) && $stable(lock_q)));
  assert_start_needs_wel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> (wel_q && wip_q));
  assert_start_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |=> !op_start_o);
  assert_bulk_unprot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_o && op_kind_o == OPK_BULK) |-> (bp_q == 3'd0));
  assert_busy_needs_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(wel_q));
  assert_done_clears_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
endmodule

// File: tb/tb_spi_flash_status_ctrl.sv
`timescale 1ns/1ps
module tb_spi_flash_status_ctrl;
  localparam int WRSR_CYC = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, op_done = 1'b0;
  logic so, oe, op_start;
  logic [1:0]  op_kind;
  logic [23:0] op_addr;

  always #4 clk = ~clk;

  spi_flash_status_ctrl #(.WRSR_CYCLES(WRSR_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .wp_ni(wp_n),
    .so_o(so), .so_oe_o(oe), .op_start_o(op_start), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_done_i(op_done)
  );

  int n_chk = 0, n_fail = 0, starts = 0;
  logic [1:0]  last_kind;
  logic [23:0] last_addr;
  logic [7:0]  tx_b [8];
  logic [7:0]  rx_b [8];
  logic mode3 = 1'b0, oe_gap;
  logic e_wel = 0, e_wip = 0, e_lock = 0;
  logic [2:0] e_bp = 0;
  int pend = 0;

  always @(negedge clk) if (op_start) begin
    starts = starts + 1;
    last_kind = op_kind;
    last_addr = op_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_status();
    return {e_lock, 2'b00, e_bp, e_wel, e_wip};
  endfunction

  function automatic logic prot(input logic [2:0] lvl, input logic [2:0] sect);
    int span;
    span = (lvl == 0) ? 0 : (1 << (lvl - 1));
    if (span > 8) span = 8;
    return (span != 0) && (int'(sect) >= 8 - span);
  endfunction

  task automatic spi_run(input int nb, input int extra);
    sck = mode3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    oe_gap = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nb * 8 + extra; k++) begin
      int b = k / 8;
      int i = 7 - (k % 8);
      sck = 1'b0;
      si = tx_b[b][i];
      repeat (4) @(negedge clk);
      rx_b[b][i] = so;
      if (b >= 1 && !oe) oe_gap = 1'b1;
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    if (!mode3) begin
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_status(input string req);
    tx_b[0] = 8'h05;
    for (int j = 1; j < 8; j++) tx_b[j] = 8'h00;
    spi_run(3, 0);
    chk(req, {24'd0, rx_b[1]}, {24'd0, e_status()});
    chk("R2 repeat", {24'd0, rx_b[2]}, {24'd0, e_status()});
    chk("R2 drive", {31'd0, oe_gap}, 32'd0);
    chk("R1 hiz", {31'd0, oe}, 32'd0);
  endtask

  task automatic finish_op(input string req);
    if (pend == 2) begin
      repeat (3) @(negedge clk);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
    end else if (pend == 1) begin
      repeat (WRSR_CYC + 20) @(negedge clk);
    end
    if (pend != 0) begin
      e_wip = 1'b0;
      e_wel = 1'b0;
      pend = 0;
      repeat (2) @(negedge clk);
      read_status(req);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d,
                        input int nb, input int extra, input bit fin);
    string tag;
    int acc, s0;
    logic [1:0] kind;
    acc = 0;
    kind = 0;
    tag = "R11";
    tx_b[0] = op;
    tx_b[1] = (op == 8'h01) ? d : a[23:16];
    tx_b[2] = a[15:8];
    tx_b[3] = a[7:0];
    for (int j = 4; j < 8; j++) tx_b[j] = d;
    if (e_wip) tag = "R10";
    else if (extra == 0) begin
      case (op)
        8'h06: if (nb == 1) begin tag = "R3"; e_wel = 1; end
        8'h04: if (nb == 1) begin tag = "R3"; e_wel = 0; end
        8'h01: if (nb == 2) begin
          if (!e_wel) tag = "R5";
          else if (e_lock && !wp_n) tag = "R6";
          else begin
            tag = "R4"; e_lock = d[7]; e_bp = d[4:2]; e_wip = 1; pend = 1;
          end
        end
        8'h02, 8'hD8: if ((op == 8'hD8) ? nb == 4 : nb >= 5) begin
          tag = prot(e_bp, a[18:16]) ? "R8" : "R7";
          if (e_wel && !prot(e_bp, a[18:16])) begin
            acc = 1; kind = (op == 8'hD8) ? 2'd2 : 2'd1;
          end
        end
        8'hC7: if (nb == 1) begin
          tag = "R9";
          if (e_wel && e_bp == 0) begin acc = 1; kind = 2'd3; end
        end
        default: ;
      endcase
    end
    s0 = starts;
    spi_run(nb, extra);
    chk({tag, " start"}, starts - s0, acc);
    if (acc != 0) begin
      chk({tag, " kind"}, {30'd0, last_kind}, {30'd0, kind});
      chk({tag, " addr"}, {8'd0, last_addr}, (kind == 2'd3) ? 32'd0 : {8'd0, a});
      e_wip = 1;
      pend = 2;
    end
    read_status(tag);
    if (fin) finish_op(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe reset", {31'd0, oe}, 32'd0);
    read_status("R1");
    // directed corners
    do_cmd(8'h01, 0, 8'h9C, 2, 0, 1);        // no latch: R5
    do_cmd(8'h06, 0, 0, 1, 0, 1);            // R3
    do_cmd(8'h04, 0, 0, 1, 0, 1);            // R3
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'h01, 0, 8'hFF, 2, 0, 1);        // R4: bits 6:5,1:0 not writable
    wp_n = 1'b0;
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'h01, 0, 8'h00, 2, 0, 1);        // R6 ignored
    wp_n = 1'b1;
    do_cmd(8'h01, 0, 8'h04, 2, 0, 1);        // R4 level 1
    mode3 = 1'b1;
    read_status("R2 mode3");
    mode3 = 1'b0;
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'hD8, 24'h07_1234, 0, 4, 0, 1);  // R8 top sector locked
    do_cmd(8'hD8, 24'h06_0010, 0, 4, 0, 0);  // R7 accepted
    do_cmd(8'h04, 0, 0, 1, 0, 0);            // R10 ignored while busy
    do_cmd(8'h06, 0, 0, 1, 0, 0);            // R10
    finish_op("R7 done");
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'hC7, 0, 0, 1, 0, 1);            // R9 rejected, level 1
    do_cmd(8'h01, 0, 8'h10, 2, 0, 1);        // level 4
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'h02, 24'h00_0000, 8'hAA, 5, 0, 1); // R8 all locked
    do_cmd(8'h01, 0, 8'h00, 2, 0, 1);
    do_cmd(8'h06, 0, 0, 1, 0, 1);
    do_cmd(8'hC7, 0, 0, 1, 0, 1);            // R9 accepted
    do_cmd(8'h06, 0, 0, 1, 3, 1);            // R11 off boundary
    do_cmd(8'h06, 0, 0, 2, 0, 1);            // R11 wrong length
    // constrained random
    for (int it = 0; it < 60; it++) begin
      logic [7:0] op, d;
      logic [23:0] a;
      int nb, ex, pick;
      pick = $urandom % 8;
      wp_n = $urandom % 2;
      mode3 = $urandom % 2;
      a = $urandom & 24'h07FFFF;
      d = $urandom;
      case (pick)
        0, 7: begin op = 8'h06; nb = 1; end
        1: begin op = 8'h04; nb = 1; end
        2: begin op = 8'h01; nb = 2; end
        3: begin op = 8'h02; nb = 5 + ($urandom % 2); end
        4: begin op = 8'hD8; nb = 4; end
        5: begin op = 8'hC7; nb = 1; end
        default: begin op = 8'h05; nb = 1; end
      endcase
      if (($urandom % 8) == 0) nb = (op == 8'h02) ? 4 : nb + 1;
      ex = (($urandom % 8) == 0) ? 1 + ($urandom % 7) : 0;
      if (op == 8'h05) read_status("R2");
      else do_cmd(op, a, d, nb, ex, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule